// File: doc/BRIEF.md
# Sensorless Motor Commutation Delay Timer

This block schedules the commutation instant of a sensorless brushless motor. It keeps an 8-bit time base that restarts at every accepted back-EMF zero crossing. Each crossing stores the elapsed count, and the older stored count moves to a second register. From one of these two measurements and a programmable weight, the block derives a delay. When that delay has elapsed, it issues a commutation event. At that event a staged phase pattern becomes active, and the block then waits for the end of demagnetization before it accepts the next zero crossing.

Zero-crossing and demagnetization-end events arrive as clean, single-cycle digital pulses. The commutation itself comes from one of two sources. In automatic mode the block computes the delay continuously and fires by itself. In manual mode software triggers the event through a command register.

When the time base overflows, the block slows down by one step: the prescaler period doubles and all stored captures are halved, so that they stay in the new units. Software reaches every register through a simple synchronous write port and a combinational read port. Four event flags can each be masked onto the interrupt output.

Top module: `bemf_commutation_timer`

## Requirements
- R1: After reset, every timing register (counter, both zero-crossing captures, demagnetization capture, delay, step ratio) reads 00h. The block waits for a zero crossing, all flags read 0, `irq` is 0 and `commutate` is 0.
- R2: The counter advances by one every 2^ratio clocks, so a ratio of 0 means every clock. Writing the step ratio (address 9, bits 3:0) or the counter (address 8) restarts the prescaler.
- R3: A zero-crossing pulse accepted while waiting for one has four effects: the current capture (address A) takes the counter value, the previous capture (address B) takes the old current capture, the counter clears to 0, and flag bit 0 sets. If a counter overflow falls in the same cycle, the zero crossing wins and no rescale happens.
- R4: A zero-crossing pulse is ignored while the block waits for the commutation or for the end of demagnetization. A demagnetization pulse is ignored in any state other than waiting for it.
- R5: The delay is weight (address 1) × source / 32, saturated to FFh. The source is the previous capture when control bit 1 (address 0) is 0, and the current capture when it is 1.
- R6: In automatic mode (control bit 0 = 1), the commutation fires on the first clock on which the counter is greater than or equal to the computed delay, and only once per step. In this mode the delay register (address 2) reads the computed value and ignores writes.
- R7: In manual mode, writing 1 to bit 0 of address 7 fires the commutation if the block is waiting for it. The block never fires by itself in manual mode, and in automatic mode that write has no effect.
- R8: At the commutation, the staged phase pattern (address 3) is copied to `phase_out` (readable at address 4) and flag bit 1 sets. `commutate` pulses high for one cycle on the following cycle.
- R9: An accepted demagnetization pulse stores the counter into the demagnetization capture (address C), sets flag bit 2, and re-enables zero-crossing detection.
- R10: On counter overflow (FFh to 00h), flag bit 3 sets. If the ratio is below Fh, the ratio also increments and all three captures are halved; at Fh the ratio and the captures stay unchanged.
- R11: Writing the flag register (address 5) clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle wins over the clear.
- R12: `irq` is high whenever any flag is set whose enable bit at the same position in the mask register (address 6) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pulse | input | 1 | Zero-crossing event pulse |
| demag_pulse | input | 1 | Demagnetization-end event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Masked event interrupt |
| commutate | output | 1 | One-cycle commutation strobe |
| phase_out | output | 8 | Active phase pattern |

## Verification
Two functions can fall in the same cycle: a zero crossing accepted on the clock where the counter rolls over from FFh, and a flag clear written on the clock where hardware sets that flag. The bench forces the counter to FFh through its write access and raises the zero-crossing pulse on the very next clock. It then expects the ratio to stay at 0, the current capture to read FFh, and only the zero-crossing flag to be set. For the flag case, it writes zero to the flag register on the same clock as a demagnetization pulse and expects the commutation flag to be cleared while the demagnetization flag survives. Randomized weights, source selections and event spacings check the commutation latency against a delay computed by the bench.

// File: rtl/bct_pkg.sv
package bct_pkg;
    localparam int CNT_W     = 8;
    localparam int RATIO_W   = 4;
    localparam int WGT_SHIFT = 5;
    localparam int ADDR_W    = 4;
    localparam int PRE_W     = (1 << RATIO_W) - 1;
    localparam int FLAG_W    = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_WEIGHT = 4'h1;
    localparam logic [ADDR_W-1:0] A_DLY    = 4'h2;
    localparam logic [ADDR_W-1:0] A_PRE    = 4'h3;
    localparam logic [ADDR_W-1:0] A_ACT    = 4'h4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h5;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'h6;
    localparam logic [ADDR_W-1:0] A_SWCMD  = 4'h7;
    localparam logic [ADDR_W-1:0] A_CNT    = 4'h8;
    localparam logic [ADDR_W-1:0] A_RATIO  = 4'h9;
    localparam logic [ADDR_W-1:0] A_ZCUR   = 4'hA;
    localparam logic [ADDR_W-1:0] A_ZPRV   = 4'hB;
    localparam logic [ADDR_W-1:0] A_DCAP   = 4'hC;

    typedef enum logic [1:0] {
        ST_WAIT_Z = 2'd0,
        ST_WAIT_C = 2'd1,
        ST_WAIT_D = 2'd2
    } step_state_e;

    typedef struct packed {
        logic ovf;
        logic d;
        logic c;
        logic z;
    } evt_flags_t;

    typedef struct packed {
        logic dsel;
        logic auto_mode;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] commute_delay(
        input logic [CNT_W-1:0] wgt,
        input logic [CNT_W-1:0] src
    );
        logic [2*CNT_W-1:0] prod;
        logic [2*CNT_W-1:0] scaled;
        prod   = {{CNT_W{1'b0}}, wgt} * {{CNT_W{1'b0}}, src};
        scaled = prod >> WGT_SHIFT;
        if (|scaled[2*CNT_W-1:CNT_W])
            return {CNT_W{1'b1}};
        return scaled[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/bct_timebase.sv
module bct_timebase
    import bct_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               ratio_we,
    input  logic [RATIO_W-1:0] ratio_wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               ovf_evt,
    output logic               rescale
);
    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] presc_lim;
    logic             tick;

    assign presc_lim = ~({PRE_W{1'b1}} << ratio_q);
    assign tick      = (presc_q == presc_lim);
    assign ovf_evt   = tick && (cnt_q == {CNT_W{1'b1}}) && !clr && !cnt_we;
    assign rescale   = ovf_evt && (ratio_q != {RATIO_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            presc_q <= '0;
            ratio_q <= '0;
        end else begin
            if (clr)
                cnt_q <= '0;
            else if (cnt_we)
                cnt_q <= cnt_wdata;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;

            if (clr || cnt_we || ratio_we || tick)
                presc_q <= '0;
            else
                presc_q <= presc_q + 1'b1;

            if (ratio_we)
                ratio_q <= ratio_wdata;
            else if (rescale)
                ratio_q <= ratio_q + 1'b1;
        end
    end

    // R3: an accepted zero crossing restarts the time base
    a_r3_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R10: the step ratio saturates at its top value
    a_r10_ratio_sat: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && !ratio_we && ratio_q == {RATIO_W{1'b1}}) |=> (ratio_q == {RATIO_W{1'b1}}));
endmodule

// File: rtl/bct_capture.sv
module bct_capture
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             z_take,
    input  logic             d_take,
    input  logic             halve,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] zcur_q,
    output logic [CNT_W-1:0] zprv_q,
    output logic [CNT_W-1:0] dcap_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            zcur_q <= '0;
            zprv_q <= '0;
            dcap_q <= '0;
        end else begin
            if (z_take) begin
                zcur_q <= cnt;
                zprv_q <= zcur_q;
            end else if (halve) begin
                zcur_q <= zcur_q >> 1;
                zprv_q <= zprv_q >> 1;
            end

            if (d_take)
                dcap_q <= cnt;
            else if (halve)
                dcap_q <= dcap_q >> 1;
        end
    end

    // R3: the older measurement moves to the previous-capture slot
    a_r3_prev_shift: assert property (@(posedge clk) disable iff (rst)
        z_take |=> (zprv_q == $past(zcur_q)));

    // R10: a rescale halves the current capture
    a_r10_halve: assert property (@(posedge clk) disable iff (rst)
        (halve && !z_take) |=> (zcur_q == ($past(zcur_q) >> 1)));
endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             z_in,
    input  logic             d_in,
    input  logic             auto_mode,
    input  logic             sw_req,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] dly_calc,
    output logic             z_take,
    output logic             c_take,
    output logic             d_take,
    output step_state_e      st_q
);
    logic c_due;

    assign c_due  = auto_mode ? (cnt >= dly_calc) : sw_req;
    assign z_take = z_in && (st_q == ST_WAIT_Z);
    assign d_take = d_in && (st_q == ST_WAIT_D);
    assign c_take = c_due && (st_q == ST_WAIT_C);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_WAIT_Z;
        else if (z_take)
            st_q <= ST_WAIT_C;
        else if (c_take)
            st_q <= ST_WAIT_D;
        else if (d_take)
            st_q <= ST_WAIT_Z;
    end

    // R4: an accepted zero crossing leads to waiting for commutation
    a_r4_z_to_wait_c: assert property (@(posedge clk) disable iff (rst)
        z_take |=> (st_q == ST_WAIT_C));

    // R6: a commutation fires at most once per step
    a_r6_c_once: assert property (@(posedge clk) disable iff (rst)
        c_take |=> !c_take);

    // R9: demagnetization end re-enables zero-crossing detection
    a_r9_d_rearm: assert property (@(posedge clk) disable iff (rst)
        d_take |=> (st_q == ST_WAIT_Z));
endmodule

// File: rtl/bct_regs.sv
module bct_regs
    import bct_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  evt_flags_t         hw_set,
    input  logic               c_take,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [CNT_W-1:0]   zcur,
    input  logic [CNT_W-1:0]   zprv,
    input  logic [CNT_W-1:0]   dcap,
    output ctrl_t              ctrl_q,
    output logic [CNT_W-1:0]   dly_calc,
    output logic               sw_req,
    output logic               cnt_we,
    output logic               ratio_we,
    output logic [CNT_W-1:0]   phase_q,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [CNT_W-1:0]  weight_q;
    logic [CNT_W-1:0]  dly_q;
    logic [CNT_W-1:0]  pre_q;
    evt_flags_t        flags_q;
    evt_flags_t        mask_q;
    evt_flags_t        keep;
    logic              wr_ctrl, wr_wgt, wr_dly, wr_pre, wr_flags, wr_mask;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_wgt   = reg_we && (reg_addr == A_WEIGHT);
    assign wr_dly   = reg_we && (reg_addr == A_DLY);
    assign wr_pre   = reg_we && (reg_addr == A_PRE);
    assign wr_flags = reg_we && (reg_addr == A_FLAGS);
    assign wr_mask  = reg_we && (reg_addr == A_MASK);
    assign cnt_we   = reg_we && (reg_addr == A_CNT);
    assign ratio_we = reg_we && (reg_addr == A_RATIO);
    assign sw_req   = reg_we && (reg_addr == A_SWCMD) && reg_wdata[0];

    assign dly_calc = commute_delay(weight_q, ctrl_q.dsel ? zcur : zprv);
    assign keep     = wr_flags ? evt_flags_t'(reg_wdata[FLAG_W-1:0]) : evt_flags_t'({FLAG_W{1'b1}});
    assign irq      = |(flags_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            weight_q <= '0;
            dly_q    <= '0;
            pre_q    <= '0;
            phase_q  <= '0;
            flags_q  <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_wgt)
                weight_q <= reg_wdata;
            if (ctrl_q.auto_mode)
                dly_q <= dly_calc;
            else if (wr_dly)
                dly_q <= reg_wdata;
            if (wr_pre)
                pre_q <= reg_wdata;
            if (c_take)
                phase_q <= pre_q;
            if (wr_mask)
                mask_q <= evt_flags_t'(reg_wdata[FLAG_W-1:0]);
            flags_q <= (flags_q & keep) | hw_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            A_WEIGHT: reg_rdata = weight_q;
            A_DLY:    reg_rdata = dly_q;
            A_PRE:    reg_rdata = pre_q;
            A_ACT:    reg_rdata = phase_q;
            A_FLAGS:  reg_rdata = {{(CNT_W-FLAG_W){1'b0}}, flags_q};
            A_MASK:   reg_rdata = {{(CNT_W-FLAG_W){1'b0}}, mask_q};
            A_CNT:    reg_rdata = cnt;
            A_RATIO:  reg_rdata = {{(CNT_W-RATIO_W){1'b0}}, ratio};
            A_ZCUR:   reg_rdata = zcur;
            A_ZPRV:   reg_rdata = zprv;
            A_DCAP:   reg_rdata = dcap;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: in automatic mode the delay register ignores software writes
    a_r6_dly_readonly: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.auto_mode && wr_dly) |=> (dly_q == $past(dly_calc)));

    // R8: the staged phase pattern becomes active at the commutation
    a_r8_phase_xfer: assert property (@(posedge clk) disable iff (rst)
        c_take |=> (phase_q == $past(pre_q)));

    // R11: a hardware set wins over a same-cycle software clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        hw_set.d |=> flags_q.d);
endmodule

// File: rtl/bemf_commutation_timer.sv
module bemf_commutation_timer
    import bct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              zc_pulse,
    input  logic              demag_pulse,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              commutate,
    output logic [CNT_W-1:0]  phase_out
);
    logic [CNT_W-1:0]   cnt;
    logic [RATIO_W-1:0] ratio;
    logic               ovf_evt, rescale;
    logic [CNT_W-1:0]   zcur, zprv, dcap;
    logic               z_take, c_take, d_take;
    step_state_e        st;
    ctrl_t              ctrl;
    logic [CNT_W-1:0]   dly_calc;
    logic               sw_req, cnt_we, ratio_we;
    evt_flags_t         hw_set;

    assign hw_set = '{ovf: ovf_evt, d: d_take, c: c_take, z: z_take};

    bct_timebase u_timebase (
        .clk         (clk),
        .rst         (rst),
        .clr         (z_take),
        .cnt_we      (cnt_we),
        .cnt_wdata   (reg_wdata),
        .ratio_we    (ratio_we),
        .ratio_wdata (reg_wdata[RATIO_W-1:0]),
        .cnt_q       (cnt),
        .ratio_q     (ratio),
        .ovf_evt     (ovf_evt),
        .rescale     (rescale)
    );

    bct_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .z_take (z_take),
        .d_take (d_take),
        .halve  (rescale),
        .cnt    (cnt),
        .zcur_q (zcur),
        .zprv_q (zprv),
        .dcap_q (dcap)
    );

    bct_sequencer u_sequencer (
        .clk       (clk),
        .rst       (rst),
        .z_in      (zc_pulse),
        .d_in      (demag_pulse),
        .auto_mode (ctrl.auto_mode),
        .sw_req    (sw_req),
        .cnt       (cnt),
        .dly_calc  (dly_calc),
        .z_take    (z_take),
        .c_take    (c_take),
        .d_take    (d_take),
        .st_q      (st)
    );

    bct_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hw_set    (hw_set),
        .c_take    (c_take),
        .cnt       (cnt),
        .ratio     (ratio),
        .zcur      (zcur),
        .zprv      (zprv),
        .dcap      (dcap),
        .ctrl_q    (ctrl),
        .dly_calc  (dly_calc),
        .sw_req    (sw_req),
        .cnt_we    (cnt_we),
        .ratio_we  (ratio_we),
        .phase_q   (phase_out),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            commutate <= 1'b0;
        else
            commutate <= c_take;
    end

    // R7: a commutation is only issued while waiting for one
    a_r7_c_in_step: assert property (@(posedge clk) disable iff (rst)
        c_take |-> (st == ST_WAIT_C));

    // R8: the commutation strobe follows the commutation by one cycle
    a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
        c_take |=> commutate);
endmodule

// File: tb/bemf_commutation_timer_tb_top.sv
module bemf_commutation_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc_pulse = 1'b0;
    logic       demag_pulse = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       commutate;
    logic [7:0] phase_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bemf_commutation_timer dut_i (
        .clk(clk), .rst(rst), .zc_pulse(zc_pulse), .demag_pulse(demag_pulse),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .commutate(commutate), .phase_out(phase_out)
    );

    localparam logic [3:0] CTRL = 4'h0, WEIGHT = 4'h1, DLY = 4'h2, PRE = 4'h3,
                           ACT = 4'h4, FLAGS = 4'h5, MASK = 4'h6, SWCMD = 4'h7,
                           CNT = 4'h8, RATIO = 4'h9, ZCUR = 4'hA, ZPRV = 4'hB, DCAP = 4'hC;

    function automatic int exp_delay(int wt, int src);
        int p;
        p = (wt * src) >> 5;
        return (p > 255) ? 255 : p;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1; zc_pulse = 1'b0; demag_pulse = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
        @(negedge clk);
    endtask

    task automatic pulse_z();
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic pulse_d();
        demag_pulse = 1'b1;
        @(negedge clk);
        demag_pulse = 1'b0;
    endtask

    task automatic wait_c(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!commutate && k < 400);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, a, b, k, dc, wt, ds, cc;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);

        // R1: reset state
        reset_dut();
        rd(CNT, v);   check("R1 cnt", v, 0);
        rd(ZCUR, v);  check("R1 zcur", v, 0);
        rd(ZPRV, v);  check("R1 zprv", v, 0);
        rd(DCAP, v);  check("R1 dcap", v, 0);
        rd(DLY, v);   check("R1 dly", v, 0);
        rd(RATIO, v); check("R1 ratio", v, 0);
        rd(FLAGS, v); check("R1 flags", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 commutate", int'(commutate), 0);

        // R2: prescaled counting
        reset_dut();
        wr(RATIO, 8'h02);
        rd(CNT, a); repeat (7) @(negedge clk); rd(CNT, b);
        check("R2 ratio2 advance", b - a, 2);
        wr(RATIO, 8'h00);
        rd(CNT, a); repeat (4) @(negedge clk); rd(CNT, b);
        check("R2 ratio0 advance", b - a, 5);

        // R3 R6 R8 R9 R12: directed automatic step
        reset_dut();
        wr(WEIGHT, 8'd64); wr(PRE, 8'hA5); wr(MASK, 8'h02); wr(CTRL, 8'h01);
        rd(CNT, v); a = v + 1;
        pulse_z();
        wait_c(k);
        check("R6 first step zero delay", k, 1);
        check("R8 phase transfer", int'(phase_out), 8'hA5);
        rd(ACT, v); check("R8 active readback", v, 8'hA5);
        check("R12 irq on C", int'(irq), 1);
        rd(FLAGS, v); check("R8 flags Z and C", v, 3);
        repeat (5) @(negedge clk);
        rd(CNT, v); dc = v + 1;
        pulse_d();
        rd(DCAP, v); check("R9 demag capture", v, dc);
        rd(FLAGS, v); check("R9 flag D", v & 4, 4);
        repeat (20) @(negedge clk);
        rd(CNT, v); b = v + 1;
        pulse_z();
        wait_c(k);
        check("R6 C latency", k, exp_delay(64, a) + 1);
        rd(ZCUR, v); check("R3 current capture", v, b);
        rd(ZPRV, v); check("R3 previous capture", v, a);
        cc = 0;
        repeat (30) begin @(negedge clk); if (commutate) cc++; end
        check("R6 single commutation", cc, 0);

        // R5 R6: randomized weights, sources and spacing
        for (int it = 0; it < 24; it++) begin
            reset_dut();
            wt = int'($urandom_range(0, 255));
            ds = int'($urandom_range(0, 1));
            wr(WEIGHT, 8'(wt)); wr(CTRL, 8'h01);
            repeat ($urandom_range(0, 60)) @(negedge clk);
            rd(CNT, v); a = v + 1;
            pulse_z();
            wait_c(k);
            wr(CTRL, ds ? 8'h03 : 8'h01);
            repeat ($urandom_range(0, 80)) @(negedge clk);
            pulse_d();
            repeat ($urandom_range(0, 60)) @(negedge clk);
            rd(CNT, v); b = v + 1;
            pulse_z();
            wait_c(k);
            check("R5 R6 random C latency", k, exp_delay(wt, ds ? b : a) + 1);
            if (k < 250) begin
                rd(DLY, v);
                check("R5 delay readback", v, exp_delay(wt, ds ? b : a));
            end
        end

        // R7: manual commutation
        reset_dut();
        wr(SWCMD, 8'h01);
        check("R7 request ignored while waiting Z", int'(commutate), 0);
        pulse_z();
        repeat (10) @(negedge clk);
        check("R7 no self firing in manual", int'(commutate), 0);
        wr(SWCMD, 8'h01);
        check("R7 manual request fires", int'(commutate), 1);
        wr(DLY, 8'h37);
        rd(DLY, v); check("R7 manual delay writable", v, 8'h37);

        // R6 R7: request and delay write ignored in automatic mode
        reset_dut();
        wr(WEIGHT, 8'hFF); wr(CTRL, 8'h03);
        repeat (50) @(negedge clk);
        pulse_z();
        wr(SWCMD, 8'h01);
        check("R7 request ignored in auto", int'(commutate), 0);
        repeat (3) @(negedge clk);
        rd(FLAGS, v); check("R7 no C flag in auto", v & 2, 0);
        wr(DLY, 8'h10);
        rd(DLY, v); check("R6 delay read-only saturated", v, 8'hFF);

        // R4: early Z and stray D ignored
        reset_dut();
        repeat (20) @(negedge clk);
        rd(CNT, v); a = v + 1;
        pulse_z();
        repeat (5) @(negedge clk);
        pulse_z();
        pulse_d();
        rd(ZCUR, v); check("R4 early Z ignored cur", v, a);
        rd(ZPRV, v); check("R4 early Z ignored prv", v, 0);
        rd(DCAP, v); check("R4 D ignored outside wait", v, 0);
        rd(FLAGS, v); check("R4 flags only Z", v, 1);

        // R10: overflow rescale and saturation
        reset_dut();
        wr(CNT, 8'd100); pulse_z();
        wr(SWCMD, 8'h01);
        repeat (3) @(negedge clk);
        rd(CNT, v); dc = v + 1;
        pulse_d();
        wr(CNT, 8'd200); pulse_z();
        wr(CNT, 8'hFF);
        @(negedge clk);
        rd(RATIO, v); check("R10 ratio step", v, 1);
        rd(ZCUR, v);  check("R10 zcur halved", v, 100);
        rd(ZPRV, v);  check("R10 zprv halved", v, 50);
        rd(DCAP, v);  check("R10 dcap halved", v, dc >> 1);
        rd(FLAGS, v); check("R10 overflow flag", v, 8'h0F);
        wr(RATIO, 8'h0F); wr(CNT, 8'hFF);
        repeat (32770) @(negedge clk);
        rd(RATIO, v); check("R10 ratio saturated", v, 15);
        rd(ZCUR, v);  check("R10 no halving at top", v, 100);

        // R3: zero crossing on the overflow clock wins
        reset_dut();
        wr(CNT, 8'hFF); pulse_z();
        rd(RATIO, v); check("R3 Z beats overflow ratio", v, 0);
        rd(ZCUR, v);  check("R3 Z beats overflow capture", v, 8'hFF);
        rd(FLAGS, v); check("R3 Z beats overflow flags", v, 1);

        // R11 R12: flag clearing and masking
        reset_dut();
        wr(MASK, 8'h02);
        pulse_z();
        check("R12 masked flag no irq", int'(irq), 0);
        wr(FLAGS, 8'h0E);
        rd(FLAGS, v); check("R11 write zero clears", v, 0);
        wr(SWCMD, 8'h01);
        check("R12 irq on enabled flag", int'(irq), 1);
        reg_we = 1'b1; reg_addr = FLAGS; reg_wdata = 8'h00; demag_pulse = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; demag_pulse = 1'b0;
        rd(FLAGS, v); check("R11 hardware set wins", v, 4);
        check("R12 irq cleared", int'(irq), 0);
        wr(MASK, 8'h04);
        check("R12 irq on D", int'(irq), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule